// File: doc/BRIEF.md
# Divided Processor and Peripheral Clock Generator

This block derives a processor clock and a slower peripheral clock from one of two reference sources. It runs entirely on a fast sampling clock. Each source reaches it as a single-cycle tick strobe: one from a crystal-derived oscillator and one from an external frequency input. A select input picks the source that feeds the dividers. The processor clock runs at one third of the selected tick rate. The peripheral clock runs at half the processor clock rate. Separately, the crystal ticks are echoed as an oscillator-rate strobe for downstream peripherals.

A synchronisation input lets several such generators share a common phase. While the input is high, all of them hold their dividers in a defined idle state. When it is released, the first selected tick starts a fresh processor-clock high phase in every generator together. A change of source is deferred to the divider boundary, so a switch never produces a truncated high or low phase.

Top module: `clkgen_top`

## Requirements
- R1: `osc_out` is high in exactly the cycle after each cycle in which `xtal_tick` is high, whatever the values of `src_sel` and `sync_in`, and is low in every other cycle.
- R2: With `sync_in` low, every three ticks of the active source make one full `cpu_clk` period. The clock is high from the tick that completes a period until the next tick, then low for the following two tick intervals (one-third duty cycle).
- R3: `src_sel` = 0 selects `xtal_tick` as the active source and `src_sel` = 1 selects `ext_tick`.
- R4: A new `src_sel` value is adopted only on the active-source tick that raises `cpu_clk` (the divider wrap), or while `sync_in` is high. The tick that causes the wrap still belongs to the old source.
- R5: `per_clk` toggles in the same cycle that `cpu_clk` falls and at no other time, so it runs at half the `cpu_clk` rate with a 50% duty cycle.
- R6: While `sync_in` is high, `cpu_clk` and `per_clk` are low and stay low after each clock edge. During this time `src_sel` is adopted immediately.
- R7: After `sync_in` falls, the first active-source tick (including one in the same cycle as the release) raises `cpu_clk`. Generators released together therefore run in phase.
- R8: Synchronous active-high `rst` drives `cpu_clk`, `per_clk` and `osc_out` low and selects the crystal source.
- R9: Ticks from the source that is not selected have no effect on `cpu_clk` or `per_clk`. Outputs change only after an active-source tick, `sync_in` or `rst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| xtal_tick | input | 1 | Single-cycle strobe at the crystal oscillator rate |
| ext_tick | input | 1 | Single-cycle strobe at the external frequency input rate |
| src_sel | input | 1 | Source request: 0 crystal, 1 external |
| sync_in | input | 1 | Phase synchronisation hold, active high |
| osc_out | output | 1 | Registered echo of the crystal strobe |
| cpu_clk | output | 1 | Processor clock, source rate divided by three |
| per_clk | output | 1 | Peripheral clock, processor rate divided by two |

## Verification
A corrupted divider phase shows up at the ports within one active tick as a misplaced `cpu_clk` edge. A wrong peripheral toggle flips the polarity of `per_clk` at the next `cpu_clk` fall. An early or late source switch moves the next `cpu_clk` rising edge onto a tick of the wrong source, which appears within three ticks of the request. The bench sweeps every divider phase at which a select change, a synchronisation pulse or its release can arrive. It runs several tick densities and drives noise on the unselected source, comparing each output every cycle against a tick count kept arithmetically.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;

    typedef enum logic {
        SRC_XTAL = 1'b0,
        SRC_EXT  = 1'b1
    } src_e;

    typedef struct packed {
        logic tick;
        logic wrap;
        logic fall;
    } div_evt_t;

    function automatic int unsigned cnt_width(input int unsigned states);
        return (states <= 2) ? 1 : $clog2(states);
    endfunction

    function automatic src_e to_src(input logic bit_val);
        return bit_val ? SRC_EXT : SRC_XTAL;
    endfunction

endpackage

// File: rtl/clkgen_src_sel.sv
module clkgen_src_sel
    import clkgen_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic hold,
    input  logic xtal_tick,
    input  logic ext_tick,
    input  logic sel_req,
    input  logic wrap,
    output logic src_tick,
    output src_e sel_act
);

    src_e sel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= SRC_XTAL;
        end else if (hold || wrap) begin
            sel_q <= to_src(sel_req);
        end
    end

    always_comb begin
        unique case (sel_q)
            SRC_EXT:  src_tick = ext_tick;
            default:  src_tick = xtal_tick;
        endcase
    end

    assign sel_act = sel_q;

    AST_SEL_AT_WRAP: assert property (@(posedge clk) disable iff (rst)
        !$stable(sel_act) |-> ($past(hold) || $past(wrap))) else $error("select changed off boundary"); // R4

endmodule

// File: rtl/clkgen_div.sv
module clkgen_div
    import clkgen_pkg::*;
#(
    parameter int unsigned DIV  = 3,
    parameter int unsigned HIGH = 1
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     hold,
    input  logic     tick,
    output logic     cpu_clk,
    output div_evt_t evt
);

    localparam int unsigned PW = cnt_width(DIV);
    typedef logic [PW-1:0] ph_t;
    localparam ph_t LAST    = ph_t'(DIV - 1);
    localparam ph_t HI_LAST = ph_t'(HIGH - 1);
    localparam ph_t HI_CNT  = ph_t'(HIGH);

    ph_t  ph_q;
    ph_t  ph_n;
    logic live;

    assign live = tick && !hold;

    always_comb begin
        if (ph_q == LAST) begin
            ph_n = '0;
        end else begin
            ph_n = ph_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            ph_q    <= LAST;
            cpu_clk <= 1'b0;
        end else if (tick) begin
            ph_q    <= ph_n;
            cpu_clk <= (ph_n < HI_CNT);
        end
    end

    always_comb begin
        evt.tick = live;
        evt.wrap = live && (ph_q == LAST);
        evt.fall = live && (ph_q == HI_LAST);
    end

    AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (rst)
        ph_q <= LAST) else $error("phase out of range"); // R2

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        $past(hold) |-> (!cpu_clk && ph_q == LAST)) else $error("divider not idle in hold"); // R6

    AST_EDGE_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        (!$stable(cpu_clk) && !$past(hold) && !$past(rst)) |-> $past(tick)) else $error("cpu edge without tick"); // R9

endmodule

// File: rtl/clkgen_pdiv.sv
module clkgen_pdiv
    import clkgen_pkg::*;
#(
    parameter int unsigned PER_DIV = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic hold,
    input  logic fall,
    output logic per_clk
);

    localparam int unsigned HALF = (PER_DIV < 2) ? 1 : PER_DIV / 2;

    logic flip;

    generate
        if (HALF == 1) begin : g_direct
            assign flip = fall;
        end else begin : g_count
            localparam int unsigned CW = cnt_width(HALF);
            typedef logic [CW-1:0] cnt_t;
            localparam cnt_t CLAST = cnt_t'(HALF - 1);
            cnt_t cnt_q;

            always_ff @(posedge clk) begin
                if (rst || hold) begin
                    cnt_q <= '0;
                end else if (fall) begin
                    cnt_q <= (cnt_q == CLAST) ? '0 : cnt_q + 1'b1;
                end
            end

            assign flip = fall && (cnt_q == CLAST);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            per_clk <= 1'b0;
        end else if (flip) begin
            per_clk <= ~per_clk;
        end
    end

    AST_PER_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        (!$stable(per_clk) && !$past(hold) && !$past(rst)) |-> $past(fall)) else $error("peripheral toggle off fall"); // R5

    AST_PER_HOLD: assert property (@(posedge clk) disable iff (rst)
        $past(hold) |-> !per_clk) else $error("peripheral clock high in hold"); // R6

endmodule

// File: rtl/clkgen_top.sv
module clkgen_top
    import clkgen_pkg::*;
#(
    parameter int unsigned CPU_DIV  = 3,
    parameter int unsigned CPU_HIGH = 1,
    parameter int unsigned PER_DIV  = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic xtal_tick,
    input  logic ext_tick,
    input  logic src_sel,
    input  logic sync_in,
    output logic osc_out,
    output logic cpu_clk,
    output logic per_clk
);

    logic     src_tick;
    src_e     sel_act;
    div_evt_t evt;

    clkgen_src_sel i_sel (
        .clk       (clk),
        .rst       (rst),
        .hold      (sync_in),
        .xtal_tick (xtal_tick),
        .ext_tick  (ext_tick),
        .sel_req   (src_sel),
        .wrap      (evt.wrap),
        .src_tick  (src_tick),
        .sel_act   (sel_act)
    );

    clkgen_div #(
        .DIV  (CPU_DIV),
        .HIGH (CPU_HIGH)
    ) i_div (
        .clk     (clk),
        .rst     (rst),
        .hold    (sync_in),
        .tick    (src_tick),
        .cpu_clk (cpu_clk),
        .evt     (evt)
    );

    clkgen_pdiv #(
        .PER_DIV (PER_DIV)
    ) i_pdiv (
        .clk     (clk),
        .rst     (rst),
        .hold    (sync_in),
        .fall    (evt.fall),
        .per_clk (per_clk)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            osc_out <= 1'b0;
        end else begin
            osc_out <= xtal_tick;
        end
    end

    AST_SYNC_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(sync_in) |-> (!cpu_clk && !per_clk)) else $error("outputs active under sync"); // R6

    AST_PER_WITH_CPU_FALL: assert property (@(posedge clk) disable iff (rst)
        (!$stable(per_clk) && !$past(rst) && !$past(sync_in)) |-> $fell(cpu_clk)) else $error("per edge without cpu fall"); // R5

    AST_OSC_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!$past(xtal_tick) && !$past(rst)) |-> !osc_out) else $error("osc strobe without crystal tick"); // R1

endmodule

// File: tb/test_clkgen_top.sv
module test_clkgen_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic xtal_tick = 1'b0;
    logic ext_tick = 1'b0;
    logic src_sel = 1'b0;
    logic sync_in = 1'b0;
    logic osc_out;
    logic cpu_clk;
    logic per_clk;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int   m_n   = 0;
    logic m_sel = 1'b0;
    logic m_osc = 1'b0;

    always #5 clk = ~clk;

    clkgen_top i_clkgen_top (
        .clk       (clk),
        .rst       (rst),
        .xtal_tick (xtal_tick),
        .ext_tick  (ext_tick),
        .src_sel   (src_sel),
        .sync_in   (sync_in),
        .osc_out   (osc_out),
        .cpu_clk   (cpu_clk),
        .per_clk   (per_clk)
    );

    function automatic logic exp_cpu(input int n);
        return (n >= 1) && (((n - 1) % 3) == 0);
    endfunction

    function automatic logic exp_per(input int n);
        return (((n + 1) / 3) % 2) == 1;
    endfunction

    task automatic check(input logic act, input logic exp, input string what, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b (n=%0d)", tag, what, act, exp, m_n);
        end
    endtask

    task automatic check_all(input string tag);
        check(cpu_clk, exp_cpu(m_n), "cpu_clk", tag);
        check(per_clk, exp_per(m_n), "per_clk", tag);
        check(osc_out, m_osc, "osc_out", "R1");
    endtask

    task automatic apply(input logic xt, input logic et, input logic sel,
                         input logic sy, input string tag);
        logic tk;
        xtal_tick = xt;
        ext_tick  = et;
        src_sel   = sel;
        sync_in   = sy;
        m_osc     = xt;
        if (sy) begin
            m_n   = 0;
            m_sel = sel;
        end else begin
            tk = m_sel ? et : xt;
            if (tk) begin
                if ((m_n % 3) == 0) m_sel = sel;
                m_n++;
            end
        end
        @(negedge clk);
        check_all(tag);
    endtask

    task automatic do_reset(input int cycles);
        rst = 1'b1;
        xtal_tick = 1'b1;
        ext_tick = 1'b1;
        src_sel = 1'b1;
        sync_in = 1'b0;
        m_n = 0;
        m_sel = 1'b0;
        m_osc = 1'b0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            check_all("R8");
        end
        rst = 1'b0;
    endtask

    initial begin
        @(negedge clk);
        do_reset(3);

        // R2 R5: dense crystal ticks
        for (int c = 0; c < 24; c++) apply(1'b1, 1'b0, 1'b0, 1'b0, "R2");

        // R9 R3: sparse crystal ticks with noise on the external source
        for (int k = 2; k <= 4; k++) begin
            for (int c = 0; c < 18; c++) apply((c % k) == 0, 1'b1, 1'b0, 1'b0, "R9");
        end

        // R4: switch requests at every divider phase, both directions
        for (int p = 0; p < 3; p++) begin
            for (int c = 0; c < p; c++) apply(1'b1, 1'b0, m_sel, 1'b0, "R4");
            for (int c = 0; c < 15; c++) apply((c % 2) == 0, (c % 3) == 0, 1'b1, 1'b0, "R4");
            for (int c = 0; c < p; c++) apply(1'b0, 1'b1, 1'b1, 1'b0, "R4");
            for (int c = 0; c < 15; c++) apply((c % 3) == 1, (c % 2) == 1, 1'b0, 1'b0, "R4");
        end

        // R3: external source alone drives the dividers once adopted
        for (int c = 0; c < 6; c++) apply(1'b0, 1'b1, 1'b1, 1'b0, "R3");
        for (int c = 0; c < 12; c++) apply(1'b1, 1'b1, 1'b1, 1'b0, "R3");
        for (int c = 0; c < 12; c++) apply(1'b0, (c % 2) == 0, 1'b1, 1'b0, "R3");

        // R6 R7: sync pulse entering at every phase of the full period
        for (int p = 0; p < 6; p++) begin
            for (int c = 0; c < p; c++) apply(1'b0, 1'b1, 1'b1, 1'b0, "R2");
            for (int c = 0; c < 3; c++) apply(1'b1, 1'b1, (c % 2) == 0, 1'b1, "R6");
            apply(1'b1, 1'b1, 1'b1, 1'b1, "R6");
            apply(1'b0, 1'b1, 1'b1, 1'b0, "R7");
            for (int c = 0; c < 7; c++) apply(1'b0, (c % 2) == 1, 1'b1, 1'b0, "R7");
        end

        // R6: select adopted during hold, release with no tick then tick
        apply(1'b0, 1'b1, 1'b0, 1'b1, "R6");
        apply(1'b0, 1'b1, 1'b0, 1'b1, "R6");
        apply(1'b0, 1'b0, 1'b0, 1'b0, "R7");
        apply(1'b0, 1'b1, 1'b0, 1'b0, "R9");
        apply(1'b1, 1'b0, 1'b0, 1'b0, "R7");
        for (int c = 0; c < 9; c++) apply(1'b1, 1'b1, 1'b0, 1'b0, "R6");

        // R8: reset in the middle of a run
        for (int c = 0; c < 4; c++) apply(1'b1, 1'b0, 1'b0, 1'b0, "R2");
        do_reset(2);
        for (int c = 0; c < 9; c++) apply(1'b1, 1'b1, 1'b0, 1'b0, "R8");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule